// File: doc/BRIEF.md
# Masked Logic-Pattern Interrupt Generator

This block raises an interrupt for one eight-line port when the port runs in bit-programmable mode. It watches the live values of the port lines, which are a mix of pins configured as inputs and latched output bits. Lines that the mask hides are left out. The remaining lines are combined with a run-time selectable function: AND, OR, NAND or NOR. When the result is true, the interrupt condition is pending.

The block holds its own mask, function code and enable. Each one is loaded through a write strobe. The pending flag is registered once per clock and stays visible whether or not the interrupt is enabled. The active-low interrupt output drives low only while the interrupt is enabled.

A mask with every bit set is illegal. The block flags it and keeps the condition inactive. Handshake lines never reach this block, so they cannot cause a pattern interrupt.

Top module: `pattern_irq_gen`

## Requirements
- R1: After the asynchronous reset `rst_n` is asserted, the block holds this state: `irq_pending`=0, `irq_n`=1, `mask_bad`=0, mask all zeros (all lines monitored) and interrupt disabled.
- R2: With `fn_in`=2'b11 (AND), the condition is true when every unmasked line is 1.
- R3: With `fn_in`=2'b01 (OR), the condition is true when at least one unmasked line is 1.
- R4: With `fn_in`=2'b00 (NAND), the condition is true when at least one unmasked line is 0. This is the function selected after reset or clear.
- R5: With `fn_in`=2'b10 (NOR), the condition is true when every unmasked line is 0.
- R6: A mask bit of 1 removes the port line with the same index from the evaluation. A mask bit of 0 keeps that line monitored.
- R7: When the mask is 8'hFF, `mask_bad`=1 and `irq_pending` stays 0 for every line pattern and function.
- R8: While `bitprog`=0, `irq_pending` is 0 regardless of the lines.
- R9: `irq_n` is 0 only while `irq_pending`=1 and the enable is set. `irq_pending` reflects the condition whether or not the enable is set.
- R10: `irq_pending` is level-sensitive. It follows the condition with one clock of latency and falls one clock after the condition goes away.
- R11: While the synchronous clear `clear_n`=0 on a clock edge, the mask returns to all zeros, the function returns to NAND, the enable is cleared and `irq_pending` goes to 0. Clear has priority over any write on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_n | input | 1 | Synchronous active-low clear of configuration and pending state |
| bitprog | input | 1 | Port is in bit-programmable mode |
| port_lines | input | 8 | Live port line values (input pins and latched output bits) |
| mask_we | input | 1 | Load `mask_in` into the mask register |
| mask_in | input | 8 | New mask; 1 = line ignored |
| fn_we | input | 1 | Load `fn_in` into the function register |
| fn_in | input | 2 | Function code: 00 NAND, 01 OR, 10 NOR, 11 AND |
| en_we | input | 1 | Load `en_in` into the enable register |
| en_in | input | 1 | Interrupt output enable |
| irq_pending | output | 1 | Registered pattern condition, for the status register |
| irq_n | output | 1 | Active-low interrupt output |
| mask_bad | output | 1 | Mask register holds the illegal all-ones value |

## Verification
Each function is tried with the all-ones, all-zeros and single-bit-differing line patterns, both with and without a mask. These patterns separate AND from OR and NAND from NOR, and they show whether the function code uses the correct bit order.

A one-bit-zero pattern is then hidden by the mask, which shows that masked lines are forced to the identity value rather than read. Further patterns are applied with the illegal all-ones mask, with bit-programmable mode off, and with the enable toggled. These show that the pending flag and the output pin are gated separately.

A pattern that comes and goes checks the level behaviour and its one-cycle latency.

// File: rtl/pattern_irq_pkg.sv
package pattern_irq_pkg;
  typedef enum logic [1:0] {
    FN_NAND = 2'b00,
    FN_OR   = 2'b01,
    FN_NOR  = 2'b10,
    FN_AND  = 2'b11
  } pat_fn_e;
endpackage

// File: rtl/pi_cfg_regs.sv
module pi_cfg_regs
  import pattern_irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_n,
  input  logic         mask_we,
  input  logic [W-1:0] mask_in,
  input  logic         fn_we,
  input  logic [1:0]   fn_in,
  input  logic         en_we,
  input  logic         en_in,
  output logic [W-1:0] mask_q,
  output pat_fn_e      fn_q,
  output logic         en_q,
  output logic         mask_bad
);
  localparam logic [W-1:0] MASK_ALL = {W{1'b1}};

  logic [W-1:0] mask_d;
  pat_fn_e      fn_d;
  logic         en_d;

  // next-state: clear wins over writes
  always_comb begin
    mask_d = mask_q;
    fn_d   = fn_q;
    en_d   = en_q;
    if (!clear_n) begin
      mask_d = '0;
      fn_d   = FN_NAND;
      en_d   = 1'b0;
    end else begin
      if (mask_we) mask_d = mask_in;
      if (fn_we)   fn_d   = pat_fn_e'(fn_in);
      if (en_we)   en_d   = en_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      fn_q   <= FN_NAND;
      en_q   <= 1'b0;
    end else begin
      mask_q <= mask_d;
      fn_q   <= fn_d;
      en_q   <= en_d;
    end
  end

  assign mask_bad = (mask_q == MASK_ALL);

  // R11: clear empties the mask and disables the interrupt
  p_clear_cfg_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> (mask_q == '0) && !en_q && (fn_q == FN_NAND));

  // R11: without clear or write, configuration holds
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && !mask_we && !en_we) |=> $stable(mask_q) && $stable(en_q));
endmodule

// File: rtl/pi_reduce.sv
module pi_reduce
  import pattern_irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] lines,
  input  logic [W-1:0] mask,
  input  pat_fn_e      fn,
  output logic         hit
);
  logic         ident;
  logic [W-1:0] eff;
  logic         all_one;
  logic         any_one;

  // identity of the reduction: 1 for AND-type, 0 for OR-type
  assign ident = (fn == FN_AND) || (fn == FN_NAND);

  for (genvar i = 0; i < W; i++) begin : g_lane
    assign eff[i] = mask[i] ? ident : lines[i];
  end

  assign all_one = &eff;
  assign any_one = |eff;

  always_comb begin
    unique case (fn)
      FN_AND:  hit = all_one;
      FN_NAND: hit = ~all_one;
      FN_OR:   hit = any_one;
      FN_NOR:  hit = ~any_one;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/pattern_irq_gen.sv
module pattern_irq_gen
  import pattern_irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_n,
  input  logic         bitprog,
  input  logic [W-1:0] port_lines,
  input  logic         mask_we,
  input  logic [W-1:0] mask_in,
  input  logic         fn_we,
  input  logic [1:0]   fn_in,
  input  logic         en_we,
  input  logic         en_in,
  output logic         irq_pending,
  output logic         irq_n,
  output logic         mask_bad
);
  logic [W-1:0] mask_q;
  pat_fn_e      fn_q;
  logic         en_q;
  logic         hit;
  logic         pend_d;
  logic         pend_q;

  pi_cfg_regs #(.W(W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_n (clear_n),
    .mask_we (mask_we),
    .mask_in (mask_in),
    .fn_we   (fn_we),
    .fn_in   (fn_in),
    .en_we   (en_we),
    .en_in   (en_in),
    .mask_q  (mask_q),
    .fn_q    (fn_q),
    .en_q    (en_q),
    .mask_bad(mask_bad)
  );

  pi_reduce #(.W(W)) u_red (
    .lines(port_lines),
    .mask (mask_q),
    .fn   (fn_q),
    .hit  (hit)
  );

  always_comb begin
    pend_d = bitprog && !mask_bad && hit;
    if (!clear_n) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign irq_pending = pend_q;
  assign irq_n       = ~(pend_q & en_q);

  // R8: no pattern interrupt outside bit-programmable mode
  p_mode_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bitprog |=> !irq_pending);

  // R7: illegal mask keeps the condition inactive
  p_bad_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_bad |=> !irq_pending);

  // R9: pin stays high while the enable is off
  p_pin_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> irq_n);

  // R11: clear drops the pending flag
  p_clear_pend_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> !irq_pending);

  // R10: a falling reduction removes the flag one cycle later
  p_level_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !irq_pending);
endmodule

// File: tb/pattern_irq_gen_tb_top.sv
`timescale 1ns/1ps
module pattern_irq_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, clear_n, bitprog;
  logic [7:0] port_lines, mask_in;
  logic       mask_we, fn_we, en_we, en_in;
  logic [1:0] fn_in;
  logic       irq_pending, irq_n, mask_bad;

  int n_checks = 0;
  int n_errors = 0;

  logic [7:0] m_mask;
  logic [1:0] m_fn;
  logic       m_en;

  always #10 clk = ~clk;

  pattern_irq_gen dut_i (
    .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .bitprog(bitprog),
    .port_lines(port_lines), .mask_we(mask_we), .mask_in(mask_in),
    .fn_we(fn_we), .fn_in(fn_in), .en_we(en_we), .en_in(en_in),
    .irq_pending(irq_pending), .irq_n(irq_n), .mask_bad(mask_bad)
  );

  function automatic bit model(input logic [7:0] l, input logic [7:0] m,
                               input logic [1:0] f, input bit bp);
    bit all1 = 1'b1;
    bit any1 = 1'b0;
    if (!bp || m == 8'hFF) return 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (!m[i]) begin
        if (!l[i]) all1 = 1'b0;
        if (l[i])  any1 = 1'b1;
      end
    end
    case (f)
      2'b11:   return all1;
      2'b00:   return !all1;
      2'b01:   return any1;
      default: return !any1;
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_mask(input logic [7:0] m);
    mask_in = m; mask_we = 1'b1; tick(1); mask_we = 1'b0; m_mask = m;
  endtask
  task automatic wr_fn(input logic [1:0] f);
    fn_in = f; fn_we = 1'b1; tick(1); fn_we = 1'b0; m_fn = f;
  endtask
  task automatic wr_en(input logic e);
    en_in = e; en_we = 1'b1; tick(1); en_we = 1'b0; m_en = e;
  endtask

  task automatic apply_and_check(input string req, input logic [7:0] l);
    bit e;
    port_lines = l;
    tick(1);
    e = model(l, m_mask, m_fn, bitprog);
    check(req, irq_pending, e);
    check(req, irq_n, ~(e & m_en));
  endtask

  task automatic t_reset;
    check("R1 pending", irq_pending, 1'b0);
    check("R1 irq_n", irq_n, 1'b1);
    check("R1 mask_bad", mask_bad, 1'b0);
    // default NAND with all lines monitored: a zero line hits
    port_lines = 8'hFE; tick(1);
    check("R1/R4 default NAND", irq_pending, 1'b1);
    check("R1 enable off", irq_n, 1'b1);
  endtask

  task automatic t_and;
    wr_mask(8'h00); wr_fn(2'b11); wr_en(1'b1);
    apply_and_check("R2 AND all ones", 8'hFF);
    apply_and_check("R2 AND one zero", 8'hEF);
    apply_and_check("R2 AND zeros", 8'h00);
  endtask

  task automatic t_or;
    wr_fn(2'b01);
    apply_and_check("R3 OR zeros", 8'h00);
    apply_and_check("R3 OR one bit", 8'h08);
    apply_and_check("R3 OR ones", 8'hFF);
  endtask

  task automatic t_nand;
    wr_fn(2'b00);
    apply_and_check("R4 NAND ones", 8'hFF);
    apply_and_check("R4 NAND one zero", 8'h7F);
  endtask

  task automatic t_nor;
    wr_fn(2'b10);
    apply_and_check("R5 NOR zeros", 8'h00);
    apply_and_check("R5 NOR one bit", 8'h40);
  endtask

  task automatic t_mask;
    wr_mask(8'h10); wr_fn(2'b11);
    apply_and_check("R6 AND masked zero", 8'hEF);
    check("R6 AND masked zero hit", irq_pending, 1'b1);
    apply_and_check("R6 AND unmasked zero", 8'hEE);
    wr_fn(2'b01); wr_mask(8'h0F);
    apply_and_check("R6 OR masked ones", 8'h0F);
    check("R6 OR masked ones no hit", irq_pending, 1'b0);
    apply_and_check("R6 OR unmasked one", 8'h8F);
  endtask

  task automatic t_illegal;
    wr_mask(8'hFF);
    check("R7 mask_bad", mask_bad, 1'b1);
    for (int f = 0; f < 4; f++) begin
      wr_fn(f[1:0]);
      port_lines = 8'h00; tick(1);
      check("R7 pending zeros", irq_pending, 1'b0);
      port_lines = 8'hFF; tick(1);
      check("R7 pending ones", irq_pending, 1'b0);
    end
    wr_mask(8'h00);
    check("R7 mask_bad cleared", mask_bad, 1'b0);
  endtask

  task automatic t_mode;
    wr_fn(2'b01); wr_mask(8'h00);
    bitprog = 1'b0;
    apply_and_check("R8 mode off", 8'hFF);
    check("R8 mode off pending", irq_pending, 1'b0);
    bitprog = 1'b1;
    apply_and_check("R8 mode on", 8'hFF);
  endtask

  task automatic t_enable;
    wr_fn(2'b11); wr_en(1'b0);
    port_lines = 8'hFF; tick(1);
    check("R9 pending when disabled", irq_pending, 1'b1);
    check("R9 pin high when disabled", irq_n, 1'b1);
    wr_en(1'b1);
    check("R9 pin low when enabled", irq_n, 1'b0);
  endtask

  task automatic t_level;
    wr_fn(2'b11); wr_mask(8'h00); wr_en(1'b1);
    port_lines = 8'h00; tick(1);
    check("R10 idle", irq_pending, 1'b0);
    @(negedge clk); port_lines = 8'hFF;
    #1 check("R10 no same-cycle response", irq_pending, 1'b0);
    tick(1);
    check("R10 rises after one edge", irq_pending, 1'b1);
    tick(3);
    check("R10 held while condition holds", irq_pending, 1'b1);
    port_lines = 8'hFD;
    tick(1);
    check("R10 falls after one edge", irq_pending, 1'b0);
    check("R10 pin released", irq_n, 1'b1);
  endtask

  task automatic t_clear;
    wr_fn(2'b01); wr_mask(8'h0F); wr_en(1'b1);
    port_lines = 8'hF0; tick(1);
    check("R11 pre-clear", irq_pending, 1'b1);
    clear_n = 1'b0; mask_in = 8'hAA; mask_we = 1'b1; en_in = 1'b1; en_we = 1'b1;
    tick(1);
    clear_n = 1'b1; mask_we = 1'b0; en_we = 1'b0;
    m_mask = 8'h00; m_fn = 2'b00; m_en = 1'b0;
    check("R11 pending cleared", irq_pending, 1'b0);
    // NAND with full mask visible: a zero on a formerly masked line hits
    port_lines = 8'hFE; tick(1);
    check("R11 mask reset and NAND", irq_pending, 1'b1);
    check("R11 enable cleared", irq_n, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; clear_n = 1'b1; bitprog = 1'b1; port_lines = 8'hFF;
    mask_in = 8'h00; mask_we = 1'b0; fn_in = 2'b00; fn_we = 1'b0;
    en_in = 1'b0; en_we = 1'b0;
    m_mask = 8'h00; m_fn = 2'b00; m_en = 1'b0;
    tick(2);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_and();
    t_or();
    t_nand();
    t_nor();
    t_mask();
    t_illegal();
    t_mode();
    t_enable();
    t_level();
    t_clear();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule